// File: doc/BRIEF.md
# Armed-Reload Watchdog Timer

This block is a watchdog for a small microcontroller. A free-running prescaler divides a single-cycle watchdog tick into coarse steps, and each step advances an up-counter. When that counter rolls over from all ones, the block issues a system reset pulse of fixed length. Software must reload the counter often enough to prevent the rollover.

A reload write counts only when two conditions hold. The enable pin must be high, and software must first have set an arm flag by writing the control register. Every successful reload clears the arm flag again, so each reload needs a fresh arming step. The enable pin also drives an output that stops the power manager from entering power-down while the watchdog is active.

Everything runs in one synchronous clock domain. The watchdog clock arrives as a tick enable, and the system reset is synchronous and active high.

Top module: `reload_guard_wdt`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cnt_value` is 0, `arm_flag` is 0 and `sys_rst_pulse` is 0.
- R2: While `wd_enable` is 1, the counter advances by one on every 2^PRE_W-th tick (2048 by default). `sys_rst_pulse` rises exactly 2048 × (256 − L) ticks after a reload with value L, and these ticks are counted from the reload edge.
- R3: When the counter rolls over from 255 to 0, `sys_rst_pulse` goes high on the next cycle and stays high for exactly 3 ticks, that is 3 cycles when the tick is asserted every cycle.
- R4: A write with `cnt_wr` = 1 while `wd_enable` = 1 and `arm_flag` = 1 loads `cnt_wdata` into the counter and clears the prescaler, so a full interval restarts from that edge.
- R5: A successful reload clears `arm_flag`. If a control write that sets the flag arrives in the same cycle as the reload, the clear wins.
- R6: While `wd_enable` = 0, the prescaler and the counter hold their values. Reload writes are ignored, and a write that is ignored for this reason leaves `arm_flag` unchanged.
- R7: A reload write while `arm_flag` = 0 is ignored and does not change `cnt_value`.
- R8: `pd_inhibit` equals `wd_enable`, so power-down is blocked whenever the watchdog is enabled.
- R9: A control write (`ctl_wr` = 1) copies bit 4 of `ctl_wdata` into `arm_flag`: 1 arms the flag and 0 disarms it. The other bits of `ctl_wdata` have no effect.
- R10: Once a reset pulse has started, it runs to its full length even if `wd_enable` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_tick | input | 1 | Single-cycle watchdog clock enable |
| wd_enable | input | 1 | Watchdog enable pin |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 4 is the arm flag |
| cnt_wr | input | 1 | Counter reload write strobe |
| cnt_wdata | input | 8 | Reload value |
| cnt_value | output | 8 | Current counter value |
| arm_flag | output | 1 | Arm flag state |
| sys_rst_pulse | output | 1 | Reset pulse issued on counter rollover |
| pd_inhibit | output | 1 | High while power-down must be blocked |

## Verification
The checker watches several rules on every cycle:
- A reload takes its value and disarms the flag.
- The counter is frozen while the block is disabled or when an unarmed write arrives.
- The counter steps by one on each prescaler wrap.
- A rollover always starts the pulse, and every pulse lasts exactly three ticks.
- The tick count from the last reload to the rollover matches the interval formula.

Some behaviours appear only in the bench's scenarios:
- The interval measured at the ports for several reload values and tick spacings.
- The priority of a disarm over a same-cycle arming write.
- The arm flag kept set across a write blocked by the enable pin.
- A pulse that outlives a falling enable.
- The reset state.
- The power-down inhibit output.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Ticks from a reload with value load_val until the counter rolls over.
  function automatic int unsigned reset_delay_ticks(input int unsigned pre_w,
                                                    input int unsigned cnt_w,
                                                    input int unsigned load_val);
    int unsigned steps;
    steps = (32'd1 << cnt_w) - load_val;
    return steps << pre_w;
  endfunction

endpackage

// File: rtl/wdt_presc.sv
module wdt_presc #(
  parameter int W = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic wrap
);
  logic [W-1:0] div_q;

  assign wrap = adv & (&div_q);

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else if (adv)   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         ovf
);
  logic [W-1:0] val_q;

  assign value = val_q;
  assign ovf   = step & (&val_q);

  always_ff @(posedge clk) begin
    if (rst)       val_q <= '0;
    else if (load) val_q <= load_val;
    else if (step) val_q <= val_q + 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic tick,
  output logic active
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst)                    left_q <= '0;
    else if (fire)              left_q <= LW'(LEN);
    else if (tick && active)    left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/reload_guard_wdt.sv
module reload_guard_wdt #(
  parameter int PRE_W     = 11,
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 3,
  parameter int CTL_W     = 8,
  parameter int ARM_BIT   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_tick,
  input  logic             wd_enable,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_value,
  output logic             arm_flag,
  output logic             sys_rst_pulse,
  output logic             pd_inhibit
);
  // Named internal events, observed by the bound checker.
  logic load_ok;
  logic run;
  logic presc_wrap;
  logic cnt_ovf;
  logic arm_q;

  assign load_ok = cnt_wr & wd_enable & arm_q;
  assign run     = wd_enable & wd_tick & ~load_ok;

  always_ff @(posedge clk) begin
    if (rst)          arm_q <= 1'b0;
    else if (load_ok) arm_q <= 1'b0;
    else if (ctl_wr)  arm_q <= ctl_wdata[ARM_BIT];
  end

  wdt_presc #(.W(PRE_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .clr  (load_ok),
    .adv  (run),
    .wrap (presc_wrap)
  );

  wdt_count #(.W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (load_ok),
    .load_val (cnt_wdata),
    .step     (presc_wrap),
    .value    (cnt_value),
    .ovf      (cnt_ovf)
  );

  wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .fire   (cnt_ovf),
    .tick   (wd_tick),
    .active (sys_rst_pulse)
  );

  assign arm_flag   = arm_q;
  assign pd_inhibit = wd_enable;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int PRE_W     = 11,
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wd_tick,
  input logic             wd_enable,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_value,
  input logic             arm_flag,
  input logic             sys_rst_pulse,
  input logic             load_ok,
  input logic             presc_wrap,
  input logic             cnt_ovf
);
  import wdt_pkg::*;

  int unsigned run_ticks;
  int unsigned base_val;
  int unsigned hi_ticks;

  always_ff @(posedge clk) begin
    if (rst || cnt_ovf) begin
      run_ticks <= 0;
      base_val  <= 0;
    end else if (load_ok) begin
      run_ticks <= 0;
      base_val  <= int'(cnt_wdata);
    end else if (wd_enable && wd_tick) begin
      run_ticks <= run_ticks + 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sys_rst_pulse) hi_ticks <= 0;
    else if (wd_tick)          hi_ticks <= hi_ticks + 1;
  end

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> cnt_value == $past(cnt_wdata)); // R4
  AST_LOAD_DISARMS: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> !arm_flag); // R5
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !wd_enable |=> $stable(cnt_value)); // R6
  AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !arm_flag && !presc_wrap) |=> $stable(cnt_value)); // R7
  AST_STEP_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    presc_wrap |=> cnt_value == CNT_W'($past(cnt_value) + 1'b1)); // R2
  AST_OVF_TIMING: assert property (@(posedge clk) disable iff (rst)
    cnt_ovf |-> (run_ticks + 1 == reset_delay_ticks(PRE_W, CNT_W, base_val))); // R2
  AST_PULSE_AFTER_OVF: assert property (@(posedge clk) disable iff (rst)
    cnt_ovf |=> sys_rst_pulse); // R3
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    hi_ticks <= PULSE_LEN); // R3
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_pulse) |-> hi_ticks == PULSE_LEN); // R10
endmodule

bind reload_guard_wdt wdt_checker #(
  .PRE_W(PRE_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_wdt_checker (
  .clk           (clk),
  .rst           (rst),
  .wd_tick       (wd_tick),
  .wd_enable     (wd_enable),
  .cnt_wr        (cnt_wr),
  .cnt_wdata     (cnt_wdata),
  .cnt_value     (cnt_value),
  .arm_flag      (arm_flag),
  .sys_rst_pulse (sys_rst_pulse),
  .load_ok       (load_ok),
  .presc_wrap    (presc_wrap),
  .cnt_ovf       (cnt_ovf)
);

// File: tb/test_reload_guard_wdt.sv
module test_reload_guard_wdt;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wd_tick = 1'b0;
  logic       wd_enable = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_value;
  logic       arm_flag;
  logic       sys_rst_pulse;
  logic       pd_inhibit;

  int checks = 0;
  int fails  = 0;

  // Bench reference state, built from the requirements.
  int       m_presc = 0;
  logic [7:0] m_cnt = '0;
  bit       m_arm   = 0;
  int       m_pulse = 0;

  always #10 clk = ~clk;

  reload_guard_wdt i_reload_guard_wdt (
    .clk(clk), .rst(rst), .wd_tick(wd_tick), .wd_enable(wd_enable),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_value(cnt_value), .arm_flag(arm_flag), .sys_rst_pulse(sys_rst_pulse),
    .pd_inhibit(pd_inhibit)
  );

  function automatic int expect_delay(input int load_val);
    int d = 0;
    for (int k = load_val; k < 256; k++) d += 2048;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit tk, input bit cw, input logic [7:0] cd,
                      input bit lw, input logic [7:0] ld);
    bit take;
    bit fire;
    wd_enable = en; wd_tick = tk; ctl_wr = cw; ctl_wdata = cd;
    cnt_wr = lw; cnt_wdata = ld;
    @(posedge clk);
    fire = 0;
    if (rst) begin
      m_presc = 0; m_cnt = '0; m_arm = 0; m_pulse = 0;
    end else begin
      take = lw && en && m_arm;
      if (take) begin
        m_cnt = ld; m_presc = 0; m_arm = 0;
      end else begin
        if (cw) m_arm = cd[4];
        if (en && tk) begin
          if (m_presc == 2047) begin
            m_presc = 0;
            fire = (m_cnt == 8'hFF);
            m_cnt = m_cnt + 8'd1;
          end else m_presc++;
        end
      end
      if (fire) m_pulse = 3;
      else if (tk && m_pulse > 0) m_pulse--;
    end
    #1;
    chk(cnt_value === m_cnt, "R2/R4 counter model", int'(cnt_value), int'(m_cnt));
    chk(arm_flag === m_arm, "R5/R9 arm model", int'(arm_flag), int'(m_arm));
    chk(sys_rst_pulse === (m_pulse > 0), "R3 pulse model", int'(sys_rst_pulse), int'(m_pulse > 0));
    chk(pd_inhibit === en, "R8 pd_inhibit", int'(pd_inhibit), int'(en));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 0, 8'h00, 0, 8'h00);
  endtask

  task automatic arm_now();
    step(1, 0, 1, 8'h10, 0, 8'h00);
  endtask

  task automatic measure(input int load_val, input int gap, input string req);
    int edges = 0;
    int hi = 0;
    arm_now();
    step(1, 1, 0, 8'h00, 1, 8'(load_val));
    while (!sys_rst_pulse && edges < 60000) begin
      step(1, (edges % gap) == gap - 1, 0, 8'h00, 0, 8'h00);
      edges++;
    end
    chk(edges == gap * expect_delay(load_val), req, edges, gap * expect_delay(load_val));
    while (sys_rst_pulse && hi < 10) begin
      step(1, 1, 0, 8'h00, 0, 8'h00);
      hi++;
    end
    chk(hi == 3, "R3 pulse length", hi, 3);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd2024);
    // R1: reset state with busy inputs
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step(1, 1, 1, 8'hFF, 1, 8'hA5);
    chk(cnt_value == 0 && !arm_flag && !sys_rst_pulse, "R1 reset state",
        int'(cnt_value), 0);
    rst = 1'b0;
    step(0, 0, 0, 8'h00, 0, 8'h00);
    chk(cnt_value == 0 && !arm_flag, "R1 after release", int'(cnt_value), 0);

    // R9: arm flag follows bit 4 only
    step(1, 0, 1, 8'hEF, 0, 8'h00);
    chk(arm_flag == 0, "R9 bit4 clear", int'(arm_flag), 0);
    step(1, 0, 1, 8'h10, 0, 8'h00);
    chk(arm_flag == 1, "R9 bit4 set", int'(arm_flag), 1);
    step(1, 0, 1, 8'h6F, 0, 8'h00);
    chk(arm_flag == 0, "R9 other bits ignored", int'(arm_flag), 0);

    // R7: unarmed reload ignored
    step(1, 0, 0, 8'h00, 1, 8'h42);
    chk(cnt_value == 0, "R7 unarmed write", int'(cnt_value), 0);

    // R4 and R5: armed reload, same-cycle arming loses
    arm_now();
    step(1, 0, 1, 8'h10, 1, 8'h37);
    chk(cnt_value == 8'h37, "R4 load value", int'(cnt_value), 8'h37);
    chk(arm_flag == 0, "R5 disarm wins", int'(arm_flag), 0);

    // R6: disabled block holds and ignores writes, arm kept
    arm_now();
    for (int i = 0; i < 3000; i++) step(0, 1, 0, 8'h00, (i == 5), 8'h99);
    chk(cnt_value == 8'h37, "R6 hold while disabled", int'(cnt_value), 8'h37);
    chk(arm_flag == 1, "R6 arm kept on blocked write", int'(arm_flag), 1);
    chk(pd_inhibit == 0, "R8 power-down allowed", int'(pd_inhibit), 0);

    // R2 and R3: interval formula at several loads and tick spacings
    measure(254, 1, "R2 interval load 254");
    measure(253, 2, "R2 interval load 253 gap 2");
    measure(255, 3, "R2 interval load 255 gap 3");

    // R10: pulse completes after enable falls
    arm_now();
    step(1, 1, 0, 8'h00, 1, 8'hFF);
    while (!sys_rst_pulse) step(1, 1, 0, 8'h00, 0, 8'h00);
    begin
      int hi = 0;
      while (sys_rst_pulse && hi < 10) begin
        step(0, 1, 0, 8'h00, 0, 8'h00);
        hi++;
      end
      chk(hi == 3, "R10 pulse after enable drop", hi, 3);
    end

    // Constrained random mix checked against the bench model
    for (int i = 0; i < 6000; i++) begin
      bit en = ($urandom % 8) != 0;
      bit tk = ($urandom % 4) != 0;
      bit cw = ($urandom % 6) == 0;
      bit lw = ($urandom % 5) == 0;
      logic [7:0] cd = 8'($urandom);
      logic [7:0] ld = ($urandom % 2) ? 8'hFF : 8'($urandom);
      step(en, tk, cw, cd, lw, ld);
    end

    finish_run();
  end
endmodule